// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block holds the in-flight instructions of a speculative out-of-order core in a circular queue of entries. At issue it claims the entry at the tail and returns that entry's index as a tag, and that tag stands in for the destination register from then on. When an execution unit broadcasts a finished result on the shared result bus, the entry named by the tag stores the value and becomes ready. Until it retires, the entry can supply that value to later instructions through the operand lookup ports.

Retirement happens only from the head of the queue and only in program order. A ready head entry either writes its value to the architectural register file or raises a store request, and then frees its slot. A branch found mispredicted at the head, or any entry whose exception flag is set when it reaches the head, empties the whole buffer. An external flush input does the same thing at any time. Execution units, reservation stations and memory sit outside the block.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `iss_ready_o` is 1 (with `iss_rs_free_i` high), no commit output is active and every lookup misses.
- R2: An accepted issue returns as tag the current tail index, and tags run 0,1,...,DEPTH-1 and then wrap to 0. `iss_ready_o` is 0 when DEPTH entries are occupied or when `iss_rs_free_i` is low, and an issue refused in that state allocates nothing.
- R3: A result bus beat for an occupied entry makes a lookup of that tag return hit=1 and the broadcast value from the next cycle on. Before that beat the lookup returns hit=0.
- R4: Only the head entry commits, and only once it is ready. A completed younger entry causes no commit while the head is still waiting.
- R5: At commit, kind 0 (register) drives `rf_we_o` with `rf_idx_o` = low bits of the destination and `rf_data_o` = value. Kind 1 (store) drives `st_req_o` with `st_addr_o` = destination and `st_data_o` = value. Kind 2 (branch) that is not mispredicted writes nothing. In every case `cmt_valid_o` and `cmt_tag_o` show the retiring entry.
- R6: Issue and commit in the same cycle are both accepted and leave the occupancy unchanged. A full buffer refuses issue even in a cycle that commits.
- R7: A branch committing with its mispredict flag set raises `flush_o` in that cycle. From the next cycle every lookup misses and the next issue gets tag 0.
- R8: An entry whose exception flag was set by its result beat makes no register write or store when it reaches the head. It raises `cmt_excep_o` and `flush_o` and empties the buffer in the same way as R7.
- R9: While `flush_i` is high no commit and no issue take place (`iss_ready_o` = 0). In the next cycle the buffer is empty and the next tag is 0.
- R10: A result bus beat whose tag names a free entry is ignored, so a later allocation of that tag reads as not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid_i | input | 1 | Issue request |
| iss_rs_free_i | input | 1 | A reservation station is available |
| iss_kind_i | input | 2 | Instruction kind: 0 register, 1 store, 2 branch |
| iss_dest_i | input | ADDR_W | Destination register number or store address |
| iss_ready_o | output | 1 | Issue would be accepted this cycle |
| iss_tag_o | output | log2(DEPTH) | Tag given to the issuing instruction |
| res_valid_i | input | 1 | Result bus beat |
| res_tag_i | input | log2(DEPTH) | Tag of the finished entry |
| res_value_i | input | DATA_W | Result value |
| res_mispred_i | input | 1 | Branch turned out mispredicted |
| res_excep_i | input | 1 | Instruction raised an exception |
| lk_tag_i | input | NUM_LOOKUP*log2(DEPTH) | Operand lookup tags, port p at bits p*log2(DEPTH) |
| lk_hit_o | output | NUM_LOOKUP | Lookup entry is occupied and ready |
| lk_value_o | output | NUM_LOOKUP*DATA_W | Lookup values |
| flush_i | input | 1 | External flush of all entries |
| cmt_valid_o | output | 1 | An entry retires this cycle |
| cmt_tag_o | output | log2(DEPTH) | Tag of the head entry |
| cmt_excep_o | output | 1 | Retiring entry carries an exception |
| rf_we_o | output | 1 | Register file write |
| rf_idx_o | output | REG_W | Register file write index |
| rf_data_o | output | DATA_W | Register file write data |
| st_req_o | output | 1 | Store request |
| st_addr_o | output | ADDR_W | Store address |
| st_data_o | output | DATA_W | Store data |
| flush_o | output | 1 | Commit-time flush (mispredict or exception) |

## Verification
The hardest state to reach from the ports is a full buffer with a ready head, where one cycle must accept a commit together with an issue and the tail has already wrapped. The stimulus gets there in steps. It first moves head and tail to the middle of the ring with a batch of committed instructions. It then fills all eight slots, retires one entry, and in the next cycle completes the new head while presenting an issue, so that the tag that comes back proves the wrap. The buffer then refills to full and is finally cleared by an external flush while its head is ready, to show that the commit is held back.

// File: rtl/spec_rob_pkg.sv
package spec_rob_pkg;

  typedef enum logic [1:0] {
    ROB_K_REG    = 2'd0,
    ROB_K_STORE  = 2'd1,
    ROB_K_BRANCH = 2'd2,
    ROB_K_RSVD   = 2'd3
  } rob_kind_e;

  // next ring position for a pointer over depth slots
  function automatic int unsigned rob_wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // occupancy after one cycle of allocation and retirement
  function automatic int unsigned rob_occ_next(int unsigned occ, logic add, logic sub);
    return occ + (add ? 1 : 0) - (sub ? 1 : 0);
  endfunction

endpackage

// File: rtl/spec_rob_ptrs.sv
module spec_rob_ptrs
  import spec_rob_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_i,
  input  logic                     retire_i,
  input  logic                     clear_i,
  output logic [$clog2(DEPTH)-1:0] head_o,
  output logic [$clog2(DEPTH)-1:0] tail_o,
  output logic                     full_o,
  output logic                     empty_o
);
  localparam int TAG_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] occ_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else if (clear_i) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (alloc_i)  tail_q <= TAG_W'(rob_wrap_inc(tail_q, DEPTH));
      if (retire_i) head_q <= TAG_W'(rob_wrap_inc(head_q, DEPTH));
      occ_q <= CNT_W'(rob_occ_next(occ_q, alloc_i, retire_i));
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign full_o  = (occ_q == CNT_W'(DEPTH));
  assign empty_o = (occ_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> !full_o) else $error("allocation into a full buffer"); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    retire_i |-> !empty_o) else $error("retirement from an empty buffer"); // R4
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (empty_o && head_q == '0 && tail_q == '0)) else $error("flush left entries"); // R7
  AST_OCC_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && retire_i && !clear_i) |=> (occ_q == $past(occ_q))) else $error("occupancy drift"); // R6

endmodule

// File: rtl/spec_rob_entries.sv
module spec_rob_entries
  import spec_rob_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int NUM_LOOKUP = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                clear_i,
  input  logic                                alloc_i,
  input  logic [$clog2(DEPTH)-1:0]            alloc_idx_i,
  input  logic [1:0]                          alloc_kind_i,
  input  logic [ADDR_W-1:0]                   alloc_dest_i,
  input  logic                                retire_i,
  input  logic [$clog2(DEPTH)-1:0]            head_idx_i,
  input  logic                                res_valid_i,
  input  logic [$clog2(DEPTH)-1:0]            res_tag_i,
  input  logic [DATA_W-1:0]                   res_value_i,
  input  logic                                res_mispred_i,
  input  logic                                res_excep_i,
  input  logic [NUM_LOOKUP*$clog2(DEPTH)-1:0] lk_tag_i,
  output logic [NUM_LOOKUP-1:0]               lk_hit_o,
  output logic [NUM_LOOKUP*DATA_W-1:0]        lk_value_o,
  output logic                                head_vld_o,
  output logic                                head_rdy_o,
  output logic [1:0]                          head_kind_o,
  output logic [ADDR_W-1:0]                   head_dest_o,
  output logic [DATA_W-1:0]                   head_val_o,
  output logic                                head_misp_o,
  output logic                                head_exc_o
);
  localparam int TAG_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  vld_q, rdy_q, misp_q, exc_q;
  logic [1:0]        kind_q [DEPTH];
  logic [ADDR_W-1:0] dest_q [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];

  // a result beat only lands on an occupied slot
  logic res_hit;
  assign res_hit = res_valid_i && vld_q[res_tag_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      rdy_q  <= '0;
      misp_q <= '0;
      exc_q  <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        kind_q[e] <= '0;
        dest_q[e] <= '0;
        val_q[e]  <= '0;
      end
    end else if (clear_i) begin
      vld_q <= '0;
      rdy_q <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (res_hit && res_tag_i == TAG_W'(e)) begin
          rdy_q[e]  <= 1'b1;
          val_q[e]  <= res_value_i;
          misp_q[e] <= res_mispred_i;
          exc_q[e]  <= res_excep_i;
        end
        if (retire_i && head_idx_i == TAG_W'(e)) begin
          vld_q[e] <= 1'b0;
          rdy_q[e] <= 1'b0;
        end
        if (alloc_i && alloc_idx_i == TAG_W'(e)) begin
          vld_q[e]  <= 1'b1;
          rdy_q[e]  <= 1'b0;
          misp_q[e] <= 1'b0;
          exc_q[e]  <= 1'b0;
          kind_q[e] <= alloc_kind_i;
          dest_q[e] <= alloc_dest_i;
        end
      end
    end
  end

  // operand lookup ports
  for (genvar p = 0; p < NUM_LOOKUP; p++) begin : g_lookup
    logic [TAG_W-1:0] tag;
    assign tag = lk_tag_i[p*TAG_W +: TAG_W];
    assign lk_hit_o[p] = vld_q[tag] && rdy_q[tag];
    assign lk_value_o[p*DATA_W +: DATA_W] = val_q[tag];
  end

  assign head_vld_o  = vld_q[head_idx_i];
  assign head_rdy_o  = rdy_q[head_idx_i];
  assign head_kind_o = kind_q[head_idx_i];
  assign head_dest_o = dest_q[head_idx_i];
  assign head_val_o  = val_q[head_idx_i];
  assign head_misp_o = misp_q[head_idx_i];
  assign head_exc_o  = exc_q[head_idx_i];

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    AST_RESULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_i && res_tag_i == TAG_W'(g) && vld_q[g] && !clear_i) |=> rdy_q[g])
      else $error("result beat not captured"); // R3
    AST_STALE_RESULT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_i && res_tag_i == TAG_W'(g) && !vld_q[g]) |=> !rdy_q[g])
      else $error("result beat landed on a free slot"); // R10
  end

endmodule

// File: rtl/spec_rob_commit.sv
module spec_rob_commit
  import spec_rob_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              head_vld_i,
  input  logic              head_rdy_i,
  input  logic [1:0]        head_kind_i,
  input  logic [ADDR_W-1:0] head_dest_i,
  input  logic [DATA_W-1:0] head_val_i,
  input  logic              head_misp_i,
  input  logic              head_exc_i,
  output logic              retire_o,
  output logic              excep_o,
  output logic              flush_o,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_idx_o,
  output logic [DATA_W-1:0] rf_data_o,
  output logic              st_req_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic [DATA_W-1:0] st_data_o
);
  logic is_reg, is_store, is_branch;

  assign is_reg    = (head_kind_i == ROB_K_REG);
  assign is_store  = (head_kind_i == ROB_K_STORE);
  assign is_branch = (head_kind_i == ROB_K_BRANCH);

  assign retire_o  = head_vld_i && head_rdy_i && !hold_i;
  assign excep_o   = retire_o && head_exc_i;
  assign flush_o   = retire_o && (head_exc_i || (is_branch && head_misp_i));
  assign rf_we_o   = retire_o && !head_exc_i && is_reg;
  assign st_req_o  = retire_o && !head_exc_i && is_store;
  assign rf_idx_o  = head_dest_i[REG_W-1:0];
  assign rf_data_o = head_val_i;
  assign st_addr_o = head_dest_i;
  assign st_data_o = head_val_i;

  AST_COMMIT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o || st_req_o || flush_o) |-> (head_vld_i && head_rdy_i)) else $error("commit of unready head"); // R4
  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we_o && st_req_o)) else $error("register write and store together"); // R5
  AST_EXCEP_SUPPRESSES: assert property (@(posedge clk) disable iff (!rst_n)
    excep_o |-> (!rf_we_o && !st_req_o && flush_o)) else $error("exception commit changed state"); // R8
  AST_HOLD_BLOCKS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |-> !(rf_we_o || st_req_o || flush_o)) else $error("commit during external flush"); // R9

endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import spec_rob_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int REG_W      = 5,
  parameter int NUM_LOOKUP = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                iss_valid_i,
  input  logic                                iss_rs_free_i,
  input  logic [1:0]                          iss_kind_i,
  input  logic [ADDR_W-1:0]                   iss_dest_i,
  output logic                                iss_ready_o,
  output logic [$clog2(DEPTH)-1:0]            iss_tag_o,
  input  logic                                res_valid_i,
  input  logic [$clog2(DEPTH)-1:0]            res_tag_i,
  input  logic [DATA_W-1:0]                   res_value_i,
  input  logic                                res_mispred_i,
  input  logic                                res_excep_i,
  input  logic [NUM_LOOKUP*$clog2(DEPTH)-1:0] lk_tag_i,
  output logic [NUM_LOOKUP-1:0]               lk_hit_o,
  output logic [NUM_LOOKUP*DATA_W-1:0]        lk_value_o,
  input  logic                                flush_i,
  output logic                                cmt_valid_o,
  output logic [$clog2(DEPTH)-1:0]            cmt_tag_o,
  output logic                                cmt_excep_o,
  output logic                                rf_we_o,
  output logic [REG_W-1:0]                    rf_idx_o,
  output logic [DATA_W-1:0]                   rf_data_o,
  output logic                                st_req_o,
  output logic [ADDR_W-1:0]                   st_addr_o,
  output logic [DATA_W-1:0]                   st_data_o,
  output logic                                flush_o
);
  localparam int TAG_W = $clog2(DEPTH);

  // named internal events
  logic             ev_alloc, ev_retire, ev_cmt_flush, ev_clear;
  logic             full, empty;
  logic [TAG_W-1:0] head, tail;

  logic              h_vld, h_rdy, h_misp, h_exc;
  logic [1:0]        h_kind;
  logic [ADDR_W-1:0] h_dest;
  logic [DATA_W-1:0] h_val;

  // flush (either source) outranks allocation
  assign ev_clear    = flush_i || ev_cmt_flush;
  assign iss_ready_o = !full && iss_rs_free_i && !ev_clear;
  assign ev_alloc    = iss_valid_i && iss_ready_o;
  assign iss_tag_o   = tail;

  spec_rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_i  (ev_alloc),
    .retire_i (ev_retire),
    .clear_i  (ev_clear),
    .head_o   (head),
    .tail_o   (tail),
    .full_o   (full),
    .empty_o  (empty)
  );

  spec_rob_entries #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_LOOKUP(NUM_LOOKUP)
  ) u_entries (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (ev_clear),
    .alloc_i       (ev_alloc),
    .alloc_idx_i   (tail),
    .alloc_kind_i  (iss_kind_i),
    .alloc_dest_i  (iss_dest_i),
    .retire_i      (ev_retire),
    .head_idx_i    (head),
    .res_valid_i   (res_valid_i),
    .res_tag_i     (res_tag_i),
    .res_value_i   (res_value_i),
    .res_mispred_i (res_mispred_i),
    .res_excep_i   (res_excep_i),
    .lk_tag_i      (lk_tag_i),
    .lk_hit_o      (lk_hit_o),
    .lk_value_o    (lk_value_o),
    .head_vld_o    (h_vld),
    .head_rdy_o    (h_rdy),
    .head_kind_o   (h_kind),
    .head_dest_o   (h_dest),
    .head_val_o    (h_val),
    .head_misp_o   (h_misp),
    .head_exc_o    (h_exc)
  );

  spec_rob_commit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_commit (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_i      (flush_i),
    .head_vld_i  (h_vld),
    .head_rdy_i  (h_rdy),
    .head_kind_i (h_kind),
    .head_dest_i (h_dest),
    .head_val_i  (h_val),
    .head_misp_i (h_misp),
    .head_exc_i  (h_exc),
    .retire_o    (ev_retire),
    .excep_o     (cmt_excep_o),
    .flush_o     (ev_cmt_flush),
    .rf_we_o     (rf_we_o),
    .rf_idx_o    (rf_idx_o),
    .rf_data_o   (rf_data_o),
    .st_req_o    (st_req_o),
    .st_addr_o   (st_addr_o),
    .st_data_o   (st_data_o)
  );

  assign cmt_valid_o = ev_retire;
  assign cmt_tag_o   = head;
  assign flush_o     = ev_cmt_flush;

  AST_FLUSH_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clear |-> !ev_alloc) else $error("issue accepted during flush"); // R9
  AST_EMPTY_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !cmt_valid_o) else $error("commit with no entries"); // R1
  AST_VALID_HEAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (h_vld && !h_rdy) |-> !cmt_valid_o) else $error("commit past a waiting head"); // R4

endmodule

// File: tb/spec_rob_bench.sv
`timescale 1ns/1ps
module spec_rob_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid, iss_rs_free;
  logic [1:0]  iss_kind;
  logic [15:0] iss_dest;
  logic        iss_ready;
  logic [2:0]  iss_tag;
  logic        res_valid;
  logic [2:0]  res_tag;
  logic [31:0] res_value;
  logic        res_mispred, res_excep;
  logic [5:0]  lk_tag;
  logic [1:0]  lk_hit;
  logic [63:0] lk_value;
  logic        flush_in;
  logic        cmt_valid, cmt_excep;
  logic [2:0]  cmt_tag;
  logic        rf_we;
  logic [4:0]  rf_idx;
  logic [31:0] rf_data;
  logic        st_req;
  logic [15:0] st_addr;
  logic [31:0] st_data;
  logic        flush_out;

  int n_chk = 0;
  int n_bad = 0;
  int exp_tag = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spec_rob u_spec_rob (
    .clk(clk), .rst_n(rst_n),
    .iss_valid_i(iss_valid), .iss_rs_free_i(iss_rs_free), .iss_kind_i(iss_kind),
    .iss_dest_i(iss_dest), .iss_ready_o(iss_ready), .iss_tag_o(iss_tag),
    .res_valid_i(res_valid), .res_tag_i(res_tag), .res_value_i(res_value),
    .res_mispred_i(res_mispred), .res_excep_i(res_excep),
    .lk_tag_i(lk_tag), .lk_hit_o(lk_hit), .lk_value_o(lk_value),
    .flush_i(flush_in), .cmt_valid_o(cmt_valid), .cmt_tag_o(cmt_tag),
    .cmt_excep_o(cmt_excep), .rf_we_o(rf_we), .rf_idx_o(rf_idx), .rf_data_o(rf_data),
    .st_req_o(st_req), .st_addr_o(st_addr), .st_data_o(st_data), .flush_o(flush_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic issue(input logic [1:0] k, input logic [15:0] d, input string req);
    iss_valid = 1'b1; iss_kind = k; iss_dest = d; #1;
    check({req, " ready"}, iss_ready, 1);
    check({req, " tag"}, iss_tag, exp_tag);
    exp_tag = (exp_tag + 1) % 8;
    tick();
    iss_valid = 1'b0;
  endtask

  task automatic complete(input logic [2:0] t, input logic [31:0] v, input logic m, input logic e);
    res_valid = 1'b1; res_tag = t; res_value = v; res_mispred = m; res_excep = e;
    tick();
    res_valid = 1'b0; res_mispred = 1'b0; res_excep = 1'b0; #1;
  endtask

  task automatic look(input logic [2:0] t0, input logic [2:0] t1);
    lk_tag = {t1, t0}; #0.2;
  endtask

  task automatic t_reset();
    look(3'd0, 3'd5);
    check("R1 ready", iss_ready, 1);
    check("R1 commit", {cmt_valid, rf_we, st_req, flush_out}, 0);
    check("R1 lookup", lk_hit, 0);
  endtask

  task automatic t_order();
    issue(2'd0, 16'd5, "R2 t0");
    issue(2'd1, 16'h1234, "R2 t1");
    issue(2'd2, 16'd0, "R2 t2");
    issue(2'd0, 16'd9, "R2 t3");
    look(3'd3, 3'd0);
    check("R3 miss before result", lk_hit[0], 0);
    complete(3'd3, 32'hA3A3_0003, 0, 0);
    look(3'd3, 3'd0);
    check("R3 hit", lk_hit[0], 1);
    check("R3 value", lk_value[31:0], 32'hA3A3_0003);
    check("R3 other miss", lk_hit[1], 0);
    check("R4 younger no commit", cmt_valid, 0);
    complete(3'd1, 32'hA1A1_0001, 0, 0);
    check("R4 head waits", {st_req, rf_we}, 0);
    complete(3'd0, 32'hA0A0_0000, 0, 0);
    check("R5 reg we", rf_we, 1);
    check("R5 reg idx", rf_idx, 5);
    check("R5 reg data", rf_data, 32'hA0A0_0000);
    check("R5 cmt tag", cmt_tag, 0);
    tick(); #1;
    check("R5 store req", {st_req, rf_we}, 2'b10);
    check("R5 store addr", st_addr, 16'h1234);
    check("R5 store data", st_data, 32'hA1A1_0001);
    tick(); #1;
    check("R4 unready branch", cmt_valid, 0);
    complete(3'd2, 32'h0, 0, 0);
    check("R5 branch commit", cmt_valid, 1);
    check("R5 branch no write", {rf_we, st_req, flush_out}, 0);
    tick(); #1;
    check("R5 in order t3", {rf_we, rf_idx}, {1'b1, 5'd9});
    tick(); #1;
    check("R4 drained", cmt_valid, 0);
  endtask

  task automatic t_full();
    iss_rs_free = 1'b0; iss_valid = 1'b1; #1;
    check("R2 rs busy", iss_ready, 0);
    tick();
    iss_valid = 1'b0; iss_rs_free = 1'b1;
    for (int i = 0; i < 8; i++) issue(2'd0, 16'(i), "R2 fill");
    iss_valid = 1'b1; #1;
    check("R2 full refuse", iss_ready, 0);
    tick();
    iss_valid = 1'b0;
    complete(3'd4, 32'h44, 0, 0);
    check("R2 wrap head", cmt_tag, 4);
    tick();
    complete(3'd5, 32'h55, 0, 0);
    check("R6 commit same cycle", cmt_valid, 1);
    issue(2'd0, 16'd3, "R6 issue with commit");
    issue(2'd0, 16'd6, "R6 last slot");
    iss_valid = 1'b1; #1;
    check("R6 full again", iss_ready, 0);
    iss_valid = 1'b0;
    complete(3'd6, 32'h66, 0, 0);
    flush_in = 1'b1; iss_valid = 1'b1; #1;
    check("R9 no commit", cmt_valid, 0);
    check("R9 no issue", iss_ready, 0);
    tick();
    flush_in = 1'b0; iss_valid = 1'b0;
    exp_tag = 0;
    look(3'd6, 3'd7);
    check("R9 emptied", lk_hit, 0);
  endtask

  task automatic t_mispredict();
    issue(2'd0, 16'd2, "R7 t0");
    issue(2'd2, 16'd0, "R7 branch");
    issue(2'd0, 16'd4, "R7 t2");
    complete(3'd2, 32'h22, 0, 0);
    complete(3'd0, 32'h20, 0, 0);
    check("R7 older commit", rf_we, 1);
    tick();
    complete(3'd1, 32'h0, 1, 0);
    check("R7 flush", flush_out, 1);
    check("R7 branch retires", cmt_valid, 1);
    check("R7 no write", rf_we, 0);
    tick();
    look(3'd2, 3'd1);
    check("R7 lookups miss", lk_hit, 0);
    exp_tag = 0;
    issue(2'd0, 16'd7, "R7 tag restart");
  endtask

  task automatic t_exception();
    issue(2'd0, 16'd8, "R8 t1");
    complete(3'd1, 32'h81, 0, 0);
    complete(3'd0, 32'h80, 0, 1);
    check("R8 no write", {rf_we, st_req}, 0);
    check("R8 flush", flush_out, 1);
    check("R8 excep flag", cmt_excep, 1);
    tick();
    look(3'd1, 3'd0);
    check("R8 emptied", lk_hit, 0);
    exp_tag = 0;
  endtask

  task automatic t_stale();
    complete(3'd3, 32'hDEAD, 0, 0);
    for (int i = 0; i < 4; i++) issue(2'd0, 16'(i), "R10 refill");
    look(3'd3, 3'd0);
    check("R10 stale ignored", lk_hit, 0);
    flush_in = 1'b1;
    tick();
    flush_in = 1'b0;
    exp_tag = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; iss_valid = 1'b0; iss_rs_free = 1'b1; iss_kind = 2'd0; iss_dest = '0;
    res_valid = 1'b0; res_tag = '0; res_value = '0; res_mispred = 1'b0; res_excep = 1'b0;
    lk_tag = '0; flush_in = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_order();
    t_full();
    t_mispredict();
    t_exception();
    t_stale();
    finish_run();
  end
endmodule